// File: doc/BRIEF.md
# Static Configuration Serial Loader

This block writes one 16-bit configuration word into a static register that sits behind a three-wire link. The three wires are a frame enable, a dedicated static clock and serial data. The host supplies the word as an upper byte and a lower byte and pulses a start request. The loader then runs the whole wire sequence by itself and holds a busy flag high until the last clock of that sequence has ended.

Every write forms a frame of 35 static clock pulses, in this order:
- one lead-in pulse with enable low;
- a fixed 16-bit unlock key, 0xB41B, sent most significant bit first;
- one turnaround pulse with data low;
- the 16 payload bits, sent most significant bit first, upper byte before lower byte;
- one closing pulse with both enable and data low.

The static clock comes from dividing the system clock. Each half period lasts `HALF` system cycles. Enable and data change only at the moment the static clock falls, or while it is low, so the receiver can sample them on the rising edge.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy_o, sclk_o, sen_o and sdi_o are all 0.
- R2: A start_i seen at a clock edge while busy_o is 0 raises busy_o from that edge on and captures the word {hi_byte_i, lo_byte_i}, with the high byte forming bits 15:8.
- R3: While busy, the static clock has a period of 2*HALF system cycles. Each pulse slot is low for HALF cycles and then high for HALF cycles. sen_o and sdi_o never change on a rising edge of sclk_o, nor while it is high.
- R4: Slot 0, the first pulse of a frame, has sen_o = 0 and sdi_o = 0.
- R5: Slots 1 to 16 have sen_o = 1 and send the key 16'hB41B, most significant bit first.
- R6: Slot 17 is the turnaround: sen_o = 1 and sdi_o = 0.
- R7: Slots 18 to 33 have sen_o = 1 and send the captured word, bit 15 first and bit 0 last.
- R8: Slot 34 has sen_o = 0 and sdi_o = 0. busy_o falls at the end of that slot's high phase, so a frame keeps busy_o high for exactly 70*HALF cycles and shows 35 rising edges of sclk_o.
- R9: A start_i while busy_o is 1 is ignored. Changes on hi_byte_i or lo_byte_i after the word is captured do not alter the frame in flight.
- R10: While busy_o is 0, sclk_o, sen_o and sdi_o stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request; acted on only while idle |
| hi_byte_i | input | BYTE_W | Upper byte of the word to load |
| lo_byte_i | input | BYTE_W | Lower byte of the word to load |
| busy_o | output | 1 | High from acceptance to the end of the closing pulse |
| sclk_o | output | 1 | Static clock |
| sen_o | output | 1 | Frame enable |
| sdi_o | output | 1 | Serial data |

## Verification
The assertions check the following on every cycle:
- the divider count stays in range and the phase toggles at each half-period boundary;
- data and enable hold steady across every rising edge and every high phase of the static clock;
- the captured word holds while busy;
- busy holds until the closing slot ends and falls right after it;
- the slot index stays inside the frame.

Some properties can only be shown by the bench scenarios, where a behavioural model predicts every output cycle by cycle and a receiver-side monitor rebuilds each frame from the rising clock edges:
- the frame content itself: the unlock key, the turnaround, the payload order and the enable pattern;
- that a start made while busy is dropped;
- that a start held high launches a new frame right after the previous one ends.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hB41B;

  // lead-in + key + turnaround + payload + closing pulse
  function automatic int frame_slots(int word_w);
    return 1 + KEY_W + 1 + word_w + 1;
  endfunction

  // key bit sent in key position idx (0 = first sent = MSB)
  function automatic logic key_bit(int idx);
    logic [KEY_W-1:0] t;
    t = UNLOCK_KEY << idx;
    return t[KEY_W-1];
  endfunction

  // slot index helpers
  function automatic int first_payload_slot();
    return KEY_W + 2;
  endfunction
endpackage

// File: rtl/cfg_phase_gen.sv
module cfg_phase_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic phase_o,
  output logic slot_end_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          half_end;

  assign half_end   = run && (cnt == CMAX);
  assign slot_end_o = half_end && phase_o;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !run) begin
      cnt     <= '0;
      phase_o <= 1'b0;
    end else if (half_end) begin
      cnt     <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);
  assert_phase_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !clr) |=> (phase_o != $past(phase_o)));
endmodule

// File: rtl/cfg_slot_seq.sv
module cfg_slot_seq #(
  parameter int SLOTS = 35,
  parameter int SW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ok,
  input  logic          slot_end,
  output logic          busy_o,
  output logic [SW-1:0] slot_o,
  output logic          done_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  assign done_o = busy_o && slot_end && (slot_o == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      slot_o <= '0;
    end else if (start_ok) begin
      busy_o <= 1'b1;
      slot_o <= '0;
    end else if (busy_o && slot_end) begin
      if (slot_o == LAST) begin
        busy_o <= 1'b0;
        slot_o <= '0;
      end else begin
        slot_o <= slot_o + 1'b1;
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy_o && slot_o == '0));
  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o <= LAST);
endmodule

// File: rtl/cfg_bit_mux.sv
module cfg_bit_mux
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SW     = 6
) (
  input  logic              busy,
  input  logic              phase,
  input  logic [SW-1:0]     slot,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              sen,
  output logic              sdi
);
  localparam int PAY0 = first_payload_slot();
  localparam int PAYN = PAY0 + WORD_W - 1;

  logic [WORD_W-1:0] shifted;

  assign sclk = busy & phase;

  always_comb begin
    int s;
    s       = int'(slot);
    sen     = 1'b0;
    sdi     = 1'b0;
    shifted = '0;
    if (busy) begin
      if (s >= 1 && s <= KEY_W) begin
        sen = 1'b1;
        sdi = key_bit(s - 1);
      end else if (s == KEY_W + 1) begin
        sen = 1'b1;
      end else if (s >= PAY0 && s <= PAYN) begin
        sen     = 1'b1;
        shifted = word << (s - PAY0);
        sdi     = shifted[WORD_W-1];
      end
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] hi_byte_i,
  input  logic [BYTE_W-1:0] lo_byte_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sen_o,
  output logic              sdi_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SLOTS  = frame_slots(WORD_W);
  localparam int SW     = $clog2(SLOTS);

  logic              start_ok;
  logic              phase;
  logic              slot_end;
  logic              frame_done;
  logic [SW-1:0]     slot;
  logic [WORD_W-1:0] word_q;

  assign start_ok = start_i && !busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n)        word_q <= '0;
    else if (start_ok) word_q <= {hi_byte_i, lo_byte_i};
  end

  cfg_phase_gen #(.HALF(HALF)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .run(busy_o),
    .phase_o(phase), .slot_end_o(slot_end)
  );

  cfg_slot_seq #(.SLOTS(SLOTS), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .slot_end(slot_end),
    .busy_o(busy_o), .slot_o(slot), .done_o(frame_done)
  );

  cfg_bit_mux #(.WORD_W(WORD_W), .SW(SW)) u_mux (
    .busy(busy_o), .phase(phase), .slot(slot), .word(word_q),
    .sclk(sclk_o), .sen(sen_o), .sdi(sdi_o)
  );

  assert_rise_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> ($stable(sdi_o) && $stable(sen_o)));
  assert_high_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> ($stable(sdi_o) && $stable(sen_o)));
  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(word_q));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(frame_done)) |=> (!busy_o || !sclk_o));
endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  localparam int HALF   = 2;
  localparam int NSLOT  = 35;
  localparam int FRAMEC = 2 * HALF * NSLOT;

  typedef struct { bit sen; bit sdi; bit sclk; int slot; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] hi_byte_i = '0;
  logic [7:0] lo_byte_i = '0;
  logic busy_o, sclk_o, sen_o, sdi_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  exp_t q[$];
  logic [15:0] last_word;
  string frame_tag = "R7";
  bit prev_sclk = 0, prev_busy = 0;
  logic [NSLOT-1:0] rx_sdi, rx_sen;
  int rx_n = 0, busy_cyc = 0;

  cfg_serial_loader #(.BYTE_W(8), .HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .hi_byte_i(hi_byte_i), .lo_byte_i(lo_byte_i),
    .busy_o(busy_o), .sclk_o(sclk_o), .sen_o(sen_o), .sdi_o(sdi_o)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string slot_req(int s);
    if (s == 0) return "R4";
    if (s <= 16) return "R5";
    if (s == 17) return "R6";
    if (s <= 33) return "R7";
    return "R8";
  endfunction

  task automatic push_frame(logic [15:0] w);
    logic [NSLOT-1:0] sdi_v, sen_v;
    sdi_v = {1'b0, 16'hB41B, 1'b0, w, 1'b0};
    sen_v = {1'b0, {17{1'b1}}, {16{1'b1}}, 1'b0};
    for (int s = 0; s < NSLOT; s++)
      for (int h = 0; h < 2 * HALF; h++)
        q.push_back('{sen: sen_v[NSLOT-1-s], sdi: sdi_v[NSLOT-1-s],
                      sclk: (h >= HALF), slot: s});
  endtask

  // one cycle: compare at negedge, then drive inputs for the next edge
  task automatic step(bit st, logic [7:0] hi, logic [7:0] lo);
    exp_t e;
    bit ebusy;
    @(negedge clk);
    if (q.size() > 0) begin e = q.pop_front(); ebusy = 1; end
    else begin e = '{sen: 0, sdi: 0, sclk: 0, slot: -1}; ebusy = 0; end
    chk(busy_o == ebusy, ebusy ? "R2" : "R8", "busy", busy_o, ebusy);
    chk(sclk_o == e.sclk, ebusy ? "R3" : "R10", "sclk", sclk_o, e.sclk);
    chk(sen_o == e.sen, ebusy ? slot_req(e.slot) : "R10", "sen", sen_o, e.sen);
    chk(sdi_o == e.sdi, ebusy ? slot_req(e.slot) : "R10", "sdi", sdi_o, e.sdi);
    // receiver-side monitor
    if (busy_o) busy_cyc++;
    if (sclk_o && !prev_sclk) begin
      rx_sdi = {rx_sdi[NSLOT-2:0], sdi_o};
      rx_sen = {rx_sen[NSLOT-2:0], sen_o};
      rx_n++;
    end
    if (prev_busy && !busy_o) begin
      chk(rx_n == NSLOT, "R8", "pulse count", rx_n, NSLOT);
      chk(busy_cyc == FRAMEC, "R8", "busy length", busy_cyc, FRAMEC);
      chk(rx_sdi[33:18] == 16'hB41B, "R5", "key", rx_sdi[33:18], 16'hB41B);
      chk(rx_sdi[16:1] == last_word, frame_tag, "payload", rx_sdi[16:1], last_word);
      chk(rx_sen == 35'h3_FFFF_FFFE, "R6", "enable pattern", rx_sen, 35'h3_FFFF_FFFE);
      rx_n = 0; busy_cyc = 0;
    end
    prev_sclk = sclk_o;
    prev_busy = busy_o;
    start_i = st; hi_byte_i = hi; lo_byte_i = lo;
    if (st && !ebusy) begin
      push_frame({hi, lo});
      last_word = {hi, lo};
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h5A, 8'hA5);
  endtask

  task automatic run_frame(logic [7:0] hi, logic [7:0] lo);
    step(1, hi, lo);
    idle(FRAMEC + 3);
  endtask

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk({busy_o, sclk_o, sen_o, sdi_o} == 4'b0, "R1", "reset outputs",
          {busy_o, sclk_o, sen_o, sdi_o}, 0);
    end
    start_i = 1'b1; hi_byte_i = 8'h12; lo_byte_i = 8'h34;  // ignored in reset
    @(negedge clk);
    rst_n = 1'b1; start_i = 1'b0;
    @(negedge clk);
    chk({busy_o, sclk_o, sen_o, sdi_o} == 4'b0, "R1", "after reset",
        {busy_o, sclk_o, sen_o, sdi_o}, 0);
    idle(4);                                   // R10 idle quiet
    frame_tag = "R7"; run_frame(8'h3C, 8'h0A); // R2 R4 R5 R6 R7 R8
    run_frame(8'h00, 8'h00);
    run_frame(8'hFF, 8'hFF);
    run_frame(8'h80, 8'h01);
    // R9: start and data changes while busy are ignored
    frame_tag = "R9";
    step(1, 8'h18, 8'h0A);
    for (int i = 0; i < FRAMEC / 2; i++) step(0, 8'hE7, 8'h7E);
    step(1, 8'hFF, 8'h00);
    step(1, 8'h00, 8'hFF);
    idle(FRAMEC);
    // start held high: back-to-back frames
    frame_tag = "R2";
    for (int i = 0; i < 2 * FRAMEC + 2; i++) step(1, 8'hC3, 8'h96);
    idle(FRAMEC + 4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule